// File: doc/BRIEF.md
# Pseudo-Address Bank Translator

This block lets a host reach four 16 KB sideways RAM banks as one flat byte space, without the host touching the bank-select register itself. Each bank gives up its first 16 bytes, which hold a ROM header, so every bank supplies 0x3FF0 usable bytes. The flat space therefore runs from 0x00000 to 0x0FFBF. The first bank number reachable this way is 4, and the banks follow in order up to 7.

The host offers one byte read or write through a valid/ready request. The block splits the pseudo-address into a bank and a window address inside 0x8000 to 0xBFFF. It then runs a fixed sequence: it saves the current select value, writes the target bank, makes one memory access, and writes the saved select value back. After that it signals completion and returns the read data.

A bank is reachable only after it has been switched from its default ROM-style mode into data mode. A request that lands in a bank still in ROM-style mode, or beyond the end of the space, completes with an error flag and causes no select write and no memory access.

Top module: `pseudo_bank_xlat`

## Requirements
- R1: After reset, `req_ready` is 1, and `cpl_valid`, `sel_we` and `mem_en` are 0. Every bank is in ROM-style mode (mode bit 0).
- R2: A pseudo-address selects bank 4 for 0x00000..0x03FEF, bank 5 for 0x03FF0..0x07FDF, bank 6 for 0x07FE0..0x0BFCF and bank 7 for 0x0BFD0..0x0FFBF. The bank number is written to the select register as `sel_wdata`.
- R3: The window address on `mem_addr` is 0x8010 plus the offset of the pseudo-address from its bank base, so each bank's first pseudo byte reaches 0x8010 and its last reaches 0xBFFF. Window bytes 0x8000..0x800F are never accessed.
- R4: A pseudo-address of 0x0FFC0 or above completes with `cpl_error`=1, with no select write and no memory access.
- R5: A request into a bank whose mode bit is 0 completes with `cpl_error`=1 and causes no access. Writing `mode_data` through `mode_wr`/`mode_bank` sets or clears the mode bit of one bank (`mode_bank` 0..3 stands for banks 4..7) and leaves the other banks unchanged.
- R6: A valid request runs in order: target-bank select write, one memory access, select restore, then completion. The first of these steps happens in the cycle after the request is accepted, and completion comes in the 4th cycle after acceptance.
- R7: A read returns on `cpl_rdata`, together with `cpl_valid`, the byte the memory delivered in the cycle after `mem_en`. A write drives `mem_we`=1 and `req_wdata` onto `mem_wdata`.
- R8: `req_ready` is 1 only while the block is idle. A request offered while the block is busy is ignored.
- R9: An error completion appears in the 1st cycle after acceptance.
- R10: The restore writes back the `sel_cur` value that was present when the request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Pseudo-address |
| req_wdata | input | 8 | Write byte |
| cpl_valid | output | 1 | One-cycle completion pulse |
| cpl_error | output | 1 | Completion carries an error |
| cpl_rdata | output | 8 | Read byte |
| mode_wr | input | 1 | Update one bank's mode bit |
| mode_bank | input | 2 | Bank index 0..3 (banks 4..7) |
| mode_data | input | 1 | 1 = data mode, 0 = ROM-style |
| sel_cur | input | 8 | Current bank-select register value |
| sel_we | output | 1 | Write the bank-select register |
| sel_wdata | output | 8 | Value for the bank-select register |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 16 | Window address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid the cycle after `mem_en` |

## Verification
The restore check relies on `sel_cur` being driven by the select register that the block itself writes. It also relies on memory returning data exactly one cycle after `mem_en`. The bench's select-register and memory models behave in exactly this way. The assertions also assume that a request's fields stay meaningful only at the acceptance edge. The bench drives them on falling edges and holds them over that edge, including the case where a second request is offered while the block is busy.

// File: rtl/pseudo_bank_xlat.sv
module pseudo_bank_xlat #(
  parameter int NBANK  = 4,
  parameter int AW     = 17,
  parameter int WW     = 16,
  parameter int DW     = 8,
  parameter int SW     = 8,
  parameter int STRIDE = 'h3FF0,
  parameter int HDR    = 16,
  parameter int FIRST  = 4,
  parameter int WBASE  = 'h8000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [AW-1:0]            req_addr,
  input  logic [DW-1:0]            req_wdata,
  output logic                     cpl_valid,
  output logic                     cpl_error,
  output logic [DW-1:0]            cpl_rdata,
  input  logic                     mode_wr,
  input  logic [$clog2(NBANK)-1:0] mode_bank,
  input  logic                     mode_data,
  input  logic [SW-1:0]            sel_cur,
  output logic                     sel_we,
  output logic [SW-1:0]            sel_wdata,
  output logic                     mem_en,
  output logic                     mem_we,
  output logic [WW-1:0]            mem_addr,
  output logic [DW-1:0]            mem_wdata,
  input  logic [DW-1:0]            mem_rdata
);
  localparam int IW    = $clog2(NBANK);
  localparam int LIMIT = NBANK * STRIDE;

  typedef enum logic [2:0] {S_IDLE, S_SEL, S_ACC, S_RST, S_DONE} st_t;
  st_t st;

  logic [NBANK-1:0] mode_q;
  logic [IW-1:0]    idx, bank_q;
  logic [AW-1:0]    base;
  logic [WW-1:0]    win, waddr_q;
  logic [SW-1:0]    saved_q;
  logic [DW-1:0]    wdata_q, rdata_q;
  logic             we_q, err_q, in_range, ok, accept;

  always_comb begin
    idx  = '0;
    base = '0;
    for (int i = 1; i < NBANK; i++)
      if (req_addr >= AW'(i * STRIDE)) begin
        idx  = IW'(i);
        base = AW'(i * STRIDE);
      end
  end

  assign in_range = req_addr < AW'(LIMIT);
  assign ok       = in_range && mode_q[idx];
  assign win      = WW'(WBASE + HDR) + WW'(req_addr - base);
  assign accept   = req_valid && req_ready;

  assign req_ready = st == S_IDLE;
  assign sel_we    = st == S_SEL || st == S_RST;
  assign sel_wdata = st == S_SEL ? SW'(FIRST) + SW'(bank_q) : saved_q;
  assign mem_en    = st == S_ACC;
  assign mem_we    = mem_en && we_q;
  assign mem_addr  = waddr_q;
  assign mem_wdata = wdata_q;
  assign cpl_valid = st == S_DONE;
  assign cpl_error = err_q;
  assign cpl_rdata = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else if (mode_wr) mode_q[mode_bank] <= mode_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      bank_q  <= '0;
      waddr_q <= '0;
      wdata_q <= '0;
      saved_q <= '0;
      rdata_q <= '0;
      we_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (accept) begin
          bank_q  <= idx;
          waddr_q <= win;
          wdata_q <= req_wdata;
          we_q    <= req_write;
          saved_q <= sel_cur;
          rdata_q <= '0;
          err_q   <= !ok;
          st      <= ok ? S_SEL : S_DONE;
        end
        S_SEL:  st <= S_ACC;
        S_ACC:  st <= S_RST;
        S_RST: begin
          if (!we_q) rdata_q <= mem_rdata;
          st <= S_DONE;
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pseudo_bank_xlat_chk.sv
module pseudo_bank_xlat_chk #(
  parameter int WW = 16,
  parameter int SW = 8,
  parameter int HDR = 16,
  parameter int WBASE = 'h8000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          cpl_valid,
  input logic          cpl_error,
  input logic [SW-1:0] sel_cur,
  input logic          sel_we,
  input logic [SW-1:0] sel_wdata,
  input logic          mem_en,
  input logic [WW-1:0] mem_addr
);
  logic [SW-1:0] saved;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) saved <= '0;
    else if (req_valid && req_ready) saved <= sel_cur;

  p_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_addr >= WW'(WBASE + HDR)) && (mem_addr <= WW'(WBASE + 'h3FFF)));

  p_sel_before_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> $past(sel_we) && !sel_we);

  p_restore_after_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we && $past(mem_en)) |-> sel_wdata == saved);

  p_cpl_after_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_error) |-> $past(sel_we) && $past(mem_en, 2));

  p_err_fast_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_error) |-> $past(req_valid && req_ready));

  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid || sel_we || mem_en) |-> !req_ready);
endmodule

bind pseudo_bank_xlat pseudo_bank_xlat_chk #(.WW(WW), .SW(SW), .HDR(HDR), .WBASE(WBASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cpl_valid(cpl_valid), .cpl_error(cpl_error), .sel_cur(sel_cur),
  .sel_we(sel_we), .sel_wdata(sel_wdata), .mem_en(mem_en), .mem_addr(mem_addr)
);

// File: tb/pseudo_bank_xlat_bench.sv
module pseudo_bank_xlat_bench;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_ready, req_write = 0;
  logic [16:0] req_addr = '0;
  logic [7:0] req_wdata = '0, cpl_rdata, sel_wdata, mem_wdata, mem_rdata;
  logic cpl_valid, cpl_error, mode_wr = 0, mode_data = 0, sel_we, mem_en, mem_we;
  logic [1:0] mode_bank = '0;
  logic [15:0] mem_addr;
  logic [7:0] selreg;

  pseudo_bank_xlat u_pseudo_bank_xlat (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .cpl_valid(cpl_valid), .cpl_error(cpl_error), .cpl_rdata(cpl_rdata),
    .mode_wr(mode_wr), .mode_bank(mode_bank), .mode_data(mode_data),
    .sel_cur(selreg), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  int vecs = 0, fails = 0, sel_cnt = 0, acc_cnt = 0;
  logic [7:0] acc_bank, acc_wdata;
  logic [15:0] acc_addr;
  logic acc_we;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) selreg <= 8'h0C;
    else if (sel_we) selreg <= sel_wdata;

  always_ff @(posedge clk) begin
    if (sel_we) sel_cnt <= sel_cnt + 1;
    if (mem_en) begin
      acc_cnt   <= acc_cnt + 1;
      acc_bank  <= selreg;
      acc_addr  <= mem_addr;
      acc_we    <= mem_we;
      acc_wdata <= mem_wdata;
      mem_rdata <= mem_addr[7:0] ^ selreg;
    end
  end

  task automatic check(string req, longint act, longint exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_mode(int b, bit d);
    @(negedge clk);
    mode_wr = 1; mode_bank = 2'(b); mode_data = d;
    @(negedge clk);
    mode_wr = 0;
  endtask

  task automatic run(string req, bit we, logic [16:0] a, logic [7:0] wd,
                     bit exp_err, logic [7:0] exp_bank, logic [15:0] exp_addr);
    int lat;
    @(negedge clk);
    sel_cnt = 0; acc_cnt = 0;
    check({req, " ready"}, req_ready, 1);
    req_valid = 1; req_write = we; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    while (!cpl_valid && lat < 20) begin @(negedge clk); lat++; end
    check({req, " latency R6 R9"}, lat, exp_err ? 1 : 4);
    check({req, " error R4 R5"}, cpl_error, exp_err);
    if (exp_err) begin
      check({req, " no select write"}, sel_cnt, 0);
      check({req, " no access"}, acc_cnt, 0);
    end else begin
      check({req, " select writes R6"}, sel_cnt, 2);
      check({req, " one access R6"}, acc_cnt, 1);
      check({req, " bank R2"}, acc_bank, exp_bank);
      check({req, " window R3"}, acc_addr, exp_addr);
      check({req, " we R7"}, acc_we, we);
      if (we) check({req, " wdata R7"}, acc_wdata, wd);
      else    check({req, " rdata R7"}, cpl_rdata, exp_addr[7:0] ^ exp_bank);
    end
    @(negedge clk);
    check({req, " restored R10"}, selreg, 8'h0C);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 ready", req_ready, 1);
    check("R1 cpl", cpl_valid, 0);
    check("R1 sel_we", sel_we, 0);
    check("R1 mem_en", mem_en, 0);
    run("R1 R5 rom default", 0, 17'h00010, 0, 1, 0, 0);
    run("R1 R5 rom default b7", 0, 17'h0C000, 0, 1, 0, 0);
  endtask

  task automatic t_map;
    for (int b = 0; b < 4; b++) set_mode(b, 1);
    run("R2 b4 first", 0, 17'h00000, 0, 0, 8'd4, 16'h8010);
    run("R2 b4 last",  0, 17'h03FEF, 0, 0, 8'd4, 16'hBFFF);
    run("R2 b5 first", 0, 17'h03FF0, 0, 0, 8'd5, 16'h8010);
    run("R2 b5 last",  0, 17'h07FDF, 0, 0, 8'd5, 16'hBFFF);
    run("R2 b6 first", 0, 17'h07FE0, 0, 0, 8'd6, 16'h8010);
    run("R2 b6 last",  0, 17'h0BFCF, 0, 0, 8'd6, 16'hBFFF);
    run("R2 b7 first", 0, 17'h0BFD0, 0, 0, 8'd7, 16'h8010);
    run("R3 b7 last",  0, 17'h0FFBF, 0, 0, 8'd7, 16'hBFFF);
    run("R3 mid b5",   0, 17'h05000, 0, 0, 8'd5, 16'h9020);
  endtask

  task automatic t_write;
    run("R7 write b7", 1, 17'h0C000, 8'hA5, 0, 8'd7, 16'h8040);
    run("R7 write b4", 1, 17'h00123, 8'h3C, 0, 8'd4, 16'h8133);
  endtask

  task automatic t_range;
    run("R4 edge", 0, 17'h0FFC0, 0, 1, 0, 0);
    run("R4 top",  0, 17'h1FFFF, 0, 1, 0, 0);
  endtask

  task automatic t_mode;
    set_mode(2, 0);
    run("R5 b6 rom", 0, 17'h08000, 0, 1, 0, 0);
    run("R5 b5 kept", 0, 17'h07000, 0, 0, 8'd5, 16'h8010 + 16'h3010);
    run("R5 b7 kept", 0, 17'h0C001, 0, 0, 8'd7, 16'h8041);
    set_mode(2, 1);
    run("R5 b6 back", 0, 17'h08000, 0, 0, 8'd6, 16'h8030);
  endtask

  task automatic t_busy;
    @(negedge clk);
    sel_cnt = 0; acc_cnt = 0;
    req_valid = 1; req_write = 0; req_addr = 17'h00100;
    @(negedge clk);
    req_addr = 17'h0BFD0;
    check("R8 not ready while busy", req_ready, 0);
    @(negedge clk);
    req_valid = 0;
    repeat (4) @(negedge clk);
    check("R8 single access", acc_cnt, 1);
    check("R8 bank of first", acc_bank, 8'd4);
    check("R8 addr of first", acc_addr, 16'h8110);
    check("R8 idle again", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_map;
    t_write;
    t_range;
    t_mode;
    t_busy;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule